// File: doc/BRIEF.md
# Programmable Chip-Select Bus Router

This block sits between a CPU address bus and the board's memory and expansion targets. It decodes every address into exactly one target: the boot ROM, the main RAM, a relocatable dual-port RAM, or one of two expansion buses. The decode is purely combinational from the address. The window registers that steer it change only on a clock edge after a software write through a small register port.

After reset the ROM window covers the whole address space, so the processor can fetch from the top of memory without any setup. Boot software then narrows the ROM window, opens the RAM and dual-port windows, and picks a default expansion bus. Any address that no window claims falls through to that default bus. Four override windows send an unclaimed address to the other bus instead.

Each window is a base register plus a mask register. The mask holds ones in the low "don't care" bits and must be a contiguous run of low ones, which makes each window a naturally aligned power of two. The dual-port RAM window has no mask register of its own; its size comes from a configuration pin.

Top module: `cs_router`

## Requirements
- R1: Until software writes, the ROM window covers every address. Reset leaves the control register at 0x01 (ROM enabled; RAM, dual-port and override windows disabled; default bus 0), the ROM base at 0 and the ROM mask at all ones.
- R2: A window matches address A when A lies in [base & ~mask, (base & ~mask) + mask]. Base bits under the mask are ignored.
- R3: When wr_en_i is high, wr_data_i is written to the register at wr_idx_i on the next rising edge. The decode uses the old value until that edge, and registers hold their value whenever wr_en_i is low. The register index map is: 0 control, 1 ROM base, 2 ROM mask, 3 RAM base, 4 RAM mask, 5 dual-port base, 6..9 override base 0..3, 10..13 override mask 0..3.
- R4: Writes to register indices 14 and 15 change no register and no decode result.
- R5: A window whose enable bit is 0 never matches. The control register bits are: bit 0 ROM enable, bit 1 RAM enable, bit 3 dual-port enable, bits 7:4 override 3..0 enables.
- R6: Exactly one of the five chip selects is high for every address. The priority is ROM, then RAM, then dual-port, then any override, then the default bus.
- R7: An address claimed by no window goes to the default bus, which is set by control bit 2: 0 selects bus 0 (bus0_cs_o) and 1 selects bus 1 (bus1_cs_o).
- R8: An address claimed only by an enabled override window goes to the bus that is not the default.
- R9: The dual-port window is 16 KB when dpr_32k_i is 0 and 32 KB when it is 1, aligned to that size at the dual-port base.
- R10: Raising the ROM base with a matching mask (for example base 0x80000, mask 0x7FFFF) shrinks the ROM window. Addresses below the new base then go to the lower-priority targets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the register port |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 4 | Register index |
| wr_data_i | input | ADDR_W | Write data (control uses bits 7:0) |
| dpr_32k_i | input | 1 | Dual-port window size: 0 = 16 KB, 1 = 32 KB |
| addr_i | input | ADDR_W | CPU address to decode |
| rom_cs_o | output | 1 | Boot ROM select |
| ram_cs_o | output | 1 | Main RAM select |
| dpr_cs_o | output | 1 | Dual-port RAM select |
| bus0_cs_o | output | 1 | Route to expansion bus 0 |
| bus1_cs_o | output | 1 | Route to expansion bus 1 |

## Verification
The bench targets two events that can fall in the same cycle: a register write, and the decode of an address that the write retargets. It drives the address during the write cycle and expects the old target, then expects the new target in the following cycle. It also stacks overlapping windows (an override over ROM, RAM over the dual-port window) so that several matchers fire on one address, and judges the result against the priority chain. A behavioural range-based model is compared on every clock, through directed phases and a long random mix of writes and addresses biased toward window edges.

// File: rtl/cs_router_pkg.sv
package cs_router_pkg;
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned NUM_OVR = 4;
  localparam int unsigned CTRL_W  = 8;

  localparam logic [IDX_W-1:0] IDX_CTRL      = 4'd0;
  localparam logic [IDX_W-1:0] IDX_ROM_BASE  = 4'd1;
  localparam logic [IDX_W-1:0] IDX_ROM_MASK  = 4'd2;
  localparam logic [IDX_W-1:0] IDX_RAM_BASE  = 4'd3;
  localparam logic [IDX_W-1:0] IDX_RAM_MASK  = 4'd4;
  localparam logic [IDX_W-1:0] IDX_DPR_BASE  = 4'd5;
  localparam logic [IDX_W-1:0] IDX_OVR_BASE0 = 4'd6;
  localparam logic [IDX_W-1:0] IDX_OVR_MASK0 = 4'd10;
  localparam logic [IDX_W-1:0] IDX_LAST      = 4'd13;

  localparam int unsigned CB_ROM_EN  = 0;
  localparam int unsigned CB_RAM_EN  = 1;
  localparam int unsigned CB_DFLT    = 2;
  localparam int unsigned CB_DPR_EN  = 3;
  localparam int unsigned CB_OVR_LSB = 4;

  localparam logic [CTRL_W-1:0] CTRL_RST = 8'h01;

  typedef enum logic [2:0] {
    TGT_ROM  = 3'd0,
    TGT_RAM  = 3'd1,
    TGT_DPR  = 3'd2,
    TGT_BUS0 = 3'd3,
    TGT_BUS1 = 3'd4
  } tgt_e;

  localparam int unsigned NUM_TGT = 5;
endpackage

// File: rtl/cs_regfile.sv
module cs_regfile
  import cs_router_pkg::*;
#(
  parameter int unsigned ADDR_W = 26
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [IDX_W-1:0]                 wr_idx_i,
  input  logic [ADDR_W-1:0]                wr_data_i,
  output logic [CTRL_W-1:0]                ctrl_o,
  output logic [ADDR_W-1:0]                rom_base_o,
  output logic [ADDR_W-1:0]                rom_mask_o,
  output logic [ADDR_W-1:0]                ram_base_o,
  output logic [ADDR_W-1:0]                ram_mask_o,
  output logic [ADDR_W-1:0]                dpr_base_o,
  output logic [NUM_OVR-1:0][ADDR_W-1:0]   ovr_base_o,
  output logic [NUM_OVR-1:0][ADDR_W-1:0]   ovr_mask_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [ADDR_W-1:0] rom_base_q, rom_mask_q, ram_base_q, ram_mask_q, dpr_base_q;
  logic [NUM_OVR-1:0][ADDR_W-1:0] ovr_base_q, ovr_mask_q;

  function automatic logic hit_idx(input logic [IDX_W-1:0] idx);
    return wr_en_i && (wr_idx_i == idx);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= CTRL_RST;
      rom_base_q <= '0;
      rom_mask_q <= '1;
      ram_base_q <= '0;
      ram_mask_q <= '0;
      dpr_base_q <= '0;
    end else begin
      if (hit_idx(IDX_CTRL))     ctrl_q     <= wr_data_i[CTRL_W-1:0];
      if (hit_idx(IDX_ROM_BASE)) rom_base_q <= wr_data_i;
      if (hit_idx(IDX_ROM_MASK)) rom_mask_q <= wr_data_i;
      if (hit_idx(IDX_RAM_BASE)) ram_base_q <= wr_data_i;
      if (hit_idx(IDX_RAM_MASK)) ram_mask_q <= wr_data_i;
      if (hit_idx(IDX_DPR_BASE)) dpr_base_q <= wr_data_i;
    end
  end

  for (genvar g = 0; g < NUM_OVR; g++) begin : g_ovr
    localparam logic [IDX_W-1:0] BI = IDX_W'(IDX_OVR_BASE0 + g);
    localparam logic [IDX_W-1:0] MI = IDX_W'(IDX_OVR_MASK0 + g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ovr_base_q[g] <= '0;
        ovr_mask_q[g] <= '0;
      end else begin
        if (hit_idx(BI)) ovr_base_q[g] <= wr_data_i;
        if (hit_idx(MI)) ovr_mask_q[g] <= wr_data_i;
      end
    end
  end

  assign ctrl_o     = ctrl_q;
  assign rom_base_o = rom_base_q;
  assign rom_mask_o = rom_mask_q;
  assign ram_base_o = ram_base_q;
  assign ram_mask_o = ram_mask_q;
  assign dpr_base_o = dpr_base_q;
  assign ovr_base_o = ovr_base_q;
  assign ovr_mask_o = ovr_mask_q;

  logic [CTRL_W+(5+2*NUM_OVR)*ADDR_W-1:0] all_regs;
  assign all_regs = {ctrl_q, rom_base_q, rom_mask_q, ram_base_q, ram_mask_q,
                     dpr_base_q, ovr_base_q, ovr_mask_q};

  p_write_lands_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == IDX_ROM_BASE) |=> rom_base_q == $past(wr_data_i));

  p_hold_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(all_regs));

  p_bad_idx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i > IDX_LAST) |=> $stable(all_regs));
endmodule

// File: rtl/cs_window_match.sv
module cs_window_match #(
  parameter int unsigned ADDR_W = 26
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic              en_i,
  output logic              hit_o
);
  // mask ones are don't-care offset bits
  assign hit_o = en_i && (((addr_i ^ base_i) & ~mask_i) == '0);
endmodule

// File: rtl/cs_priority.sv
module cs_priority
  import cs_router_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rom_hit_i,
  input  logic               ram_hit_i,
  input  logic               dpr_hit_i,
  input  logic [NUM_OVR-1:0] ovr_hit_i,
  input  logic               dflt_sel_i,
  output logic [NUM_TGT-1:0] sel_o
);
  tgt_e tgt;
  tgt_e dflt_tgt, alt_tgt;

  always_comb begin
    dflt_tgt = dflt_sel_i ? TGT_BUS1 : TGT_BUS0;
    alt_tgt  = dflt_sel_i ? TGT_BUS0 : TGT_BUS1;
    if (rom_hit_i)       tgt = TGT_ROM;
    else if (ram_hit_i)  tgt = TGT_RAM;
    else if (dpr_hit_i)  tgt = TGT_DPR;
    else if (|ovr_hit_i) tgt = alt_tgt;
    else                 tgt = dflt_tgt;
  end

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_sel
    assign sel_o[t] = (tgt == tgt_e'(t));
  end

  p_one_target_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sel_o) == 1);

  p_rom_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_hit_i |-> sel_o[TGT_ROM]);

  p_ovr_redirect_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rom_hit_i && !ram_hit_i && !dpr_hit_i && (|ovr_hit_i))
      |-> (dflt_sel_i ? sel_o[TGT_BUS0] : sel_o[TGT_BUS1]));

  p_fallthrough_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rom_hit_i && !ram_hit_i && !dpr_hit_i && !(|ovr_hit_i))
      |-> (dflt_sel_i ? sel_o[TGT_BUS1] : sel_o[TGT_BUS0]));
endmodule

// File: rtl/cs_router.sv
module cs_router
  import cs_router_pkg::*;
#(
  parameter int unsigned ADDR_W          = 26,
  parameter int unsigned DPR_SMALL_BYTES = 16384
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_idx_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic              dpr_32k_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rom_cs_o,
  output logic              ram_cs_o,
  output logic              dpr_cs_o,
  output logic              bus0_cs_o,
  output logic              bus1_cs_o
);
  localparam logic [ADDR_W-1:0] DPR_MASK_S = ADDR_W'(DPR_SMALL_BYTES - 1);
  localparam logic [ADDR_W-1:0] DPR_MASK_L = ADDR_W'(2 * DPR_SMALL_BYTES - 1);

  logic [CTRL_W-1:0]              ctrl;
  logic [ADDR_W-1:0]              rom_base, rom_mask, ram_base, ram_mask, dpr_base;
  logic [NUM_OVR-1:0][ADDR_W-1:0] ovr_base, ovr_mask;
  logic [ADDR_W-1:0]              dpr_mask;
  logic                           rom_hit, ram_hit, dpr_hit;
  logic [NUM_OVR-1:0]             ovr_hit;
  logic [NUM_TGT-1:0]             sel;

  cs_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_data_i  (wr_data_i),
    .ctrl_o     (ctrl),
    .rom_base_o (rom_base),
    .rom_mask_o (rom_mask),
    .ram_base_o (ram_base),
    .ram_mask_o (ram_mask),
    .dpr_base_o (dpr_base),
    .ovr_base_o (ovr_base),
    .ovr_mask_o (ovr_mask)
  );

  assign dpr_mask = dpr_32k_i ? DPR_MASK_L : DPR_MASK_S;

  cs_window_match #(.ADDR_W(ADDR_W)) u_rom_win (
    .addr_i (addr_i), .base_i (rom_base), .mask_i (rom_mask),
    .en_i (ctrl[CB_ROM_EN]), .hit_o (rom_hit));

  cs_window_match #(.ADDR_W(ADDR_W)) u_ram_win (
    .addr_i (addr_i), .base_i (ram_base), .mask_i (ram_mask),
    .en_i (ctrl[CB_RAM_EN]), .hit_o (ram_hit));

  cs_window_match #(.ADDR_W(ADDR_W)) u_dpr_win (
    .addr_i (addr_i), .base_i (dpr_base), .mask_i (dpr_mask),
    .en_i (ctrl[CB_DPR_EN]), .hit_o (dpr_hit));

  for (genvar g = 0; g < NUM_OVR; g++) begin : g_ovr_win
    cs_window_match #(.ADDR_W(ADDR_W)) u_win (
      .addr_i (addr_i), .base_i (ovr_base[g]), .mask_i (ovr_mask[g]),
      .en_i (ctrl[CB_OVR_LSB+g]), .hit_o (ovr_hit[g]));
  end

  cs_priority u_prio (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rom_hit_i  (rom_hit),
    .ram_hit_i  (ram_hit),
    .dpr_hit_i  (dpr_hit),
    .ovr_hit_i  (ovr_hit),
    .dflt_sel_i (ctrl[CB_DFLT]),
    .sel_o      (sel)
  );

  assign rom_cs_o  = sel[TGT_ROM];
  assign ram_cs_o  = sel[TGT_RAM];
  assign dpr_cs_o  = sel[TGT_DPR];
  assign bus0_cs_o = sel[TGT_BUS0];
  assign bus1_cs_o = sel[TGT_BUS1];

  p_boot_rom_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> rom_cs_o);

  p_disabled_dpr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl[CB_DPR_EN] |-> !dpr_cs_o);
endmodule

// File: tb/cs_router_tb_top.sv
module cs_router_tb_top;
  localparam int unsigned AW = 26;
  localparam int unsigned AMASK = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_idx = '0;
  logic [AW-1:0] wr_data = '0;
  logic          dpr_32k = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          rom_cs, ram_cs, dpr_cs, bus0_cs, bus1_cs;

  int unsigned errors = 0;
  int unsigned checks = 0;
  bit          done = 0;
  int unsigned m_reg [0:13];

  always #10 clk = ~clk;

  cs_router #(.ADDR_W(AW)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en), .wr_idx_i (wr_idx),
    .wr_data_i (wr_data), .dpr_32k_i (dpr_32k), .addr_i (addr),
    .rom_cs_o (rom_cs), .ram_cs_o (ram_cs), .dpr_cs_o (dpr_cs),
    .bus0_cs_o (bus0_cs), .bus1_cs_o (bus1_cs)
  );

  function automatic bit in_win(int unsigned a, int unsigned base, int unsigned mask);
    int unsigned lo;
    lo = base & ~mask & AMASK;
    return (a >= lo) && (a <= lo + (mask & AMASK));
  endfunction

  // 0 rom, 1 ram, 2 dpr, 3 bus0, 4 bus1
  function automatic int exp_tgt(int unsigned a);
    int unsigned c = m_reg[0];
    int dflt = c[2] ? 4 : 3;
    int unsigned dmask = dpr_32k ? 32767 : 16383;
    if (c[0] && in_win(a, m_reg[1], m_reg[2])) return 0;
    if (c[1] && in_win(a, m_reg[3], m_reg[4])) return 1;
    if (c[3] && in_win(a, m_reg[5], dmask)) return 2;
    for (int i = 0; i < 4; i++)
      if (c[4+i] && in_win(a, m_reg[6+i], m_reg[10+i])) return 7 - dflt;
    return dflt;
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < 14; i++) m_reg[i] = 0;
    m_reg[0] = 1;
    m_reg[2] = AMASK;
  endfunction

  task automatic check(input string tag);
    logic [4:0] got, exp;
    got = {bus1_cs, bus0_cs, dpr_cs, ram_cs, rom_cs};
    exp = 5'(1 << exp_tgt(int'(addr)));
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr=%h got=%b exp=%b", tag, addr, got, exp);
    end
  endtask

  task automatic cyc(input bit we, input int unsigned idx, input int unsigned d,
                     input int unsigned a, input string tag);
    @(negedge clk);
    wr_en = we; wr_idx = 4'(idx); wr_data = AW'(d); addr = AW'(a);
    #5 check(tag);
    @(posedge clk);
    if (rst_n && we && idx < 14) m_reg[idx] = (idx == 0) ? (d & 255) : (d & AMASK);
  endtask

  task automatic look(input int unsigned a, input string tag);
    cyc(0, 0, 0, a, tag);
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    // R1: reset state, whole space is ROM
    look(32'h0, "R1");
    look(AMASK, "R1");
    #3 rst_n = 1'b1;
    look(32'h0, "R1");
    look(32'h80000, "R1");
    look(AMASK, "R1");
    // R10 / R3: shrink ROM; address 0 decoded in the write cycle keeps old target
    cyc(1, 1, 32'h80000, 32'h0, "R3");
    look(32'h0, "R3");
    cyc(1, 2, 32'h7FFFF, 32'h0, "R3");
    look(32'h0, "R10");
    look(32'h7FFFF, "R10");
    look(32'h80000, "R10");
    look(32'hFFFFF, "R10");
    look(32'h100000, "R10");
    // RAM window
    cyc(1, 3, 32'h0, 32'h10000, "R7");
    cyc(1, 4, 32'h3FFFF, 32'h10000, "R5");
    look(32'h10000, "R5");
    cyc(1, 0, 32'h03, 32'h10000, "R3");
    look(32'h10000, "R2");
    look(32'h3FFFF, "R2");
    look(32'h40000, "R7");
    look(32'h48000, "R7");
    cyc(1, 0, 32'h07, 32'h48000, "R7");
    look(32'h48000, "R7");
    // dual-port RAM, base with stray low bits
    cyc(1, 5, 32'h41234, 32'h40000, "R9");
    cyc(1, 0, 32'h0F, 32'h40000, "R9");
    look(32'h40000, "R9");
    look(32'h43FFF, "R9");
    look(32'h44000, "R9");
    dpr_32k = 1'b1;
    look(32'h44000, "R9");
    look(32'h47FFF, "R9");
    look(32'h48000, "R9");
    dpr_32k = 1'b0;
    // overrides
    cyc(1, 6, 32'h50000, 32'h50010, "R8");
    cyc(1, 10, 32'hFFFF, 32'h50010, "R8");
    cyc(1, 0, 32'h1F, 32'h50010, "R8");
    look(32'h50010, "R8");
    look(32'h60000, "R7");
    cyc(1, 0, 32'h1B, 32'h50010, "R8");
    look(32'h50010, "R8");
    cyc(1, 9, 32'h80000, 32'h90000, "R6");
    cyc(1, 13, 32'hFFFFF, 32'h90000, "R6");
    cyc(1, 0, 32'h9B, 32'h90000, "R6");
    look(32'h90000, "R6");
    look(32'h10000, "R6");
    // RAM overlaps dual-port: RAM wins
    cyc(1, 5, 32'h8000, 32'h8000, "R6");
    look(32'h8000, "R6");
    // R4: unused indices
    cyc(1, 14, 32'h0, 32'h8000, "R4");
    cyc(1, 15, 32'h0, 32'h8000, "R4");
    look(32'h8000, "R4");
    look(32'h90000, "R4");
    // R5: disable ROM, override 3 then claims the old ROM area
    cyc(1, 0, 32'h9A, 32'h90000, "R5");
    look(32'h90000, "R5");
    cyc(1, 0, 32'h1A, 32'h90000, "R5");
    look(32'h90000, "R5");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int unsigned idx, d, a, pick;
      bit we;
      we = ($urandom % 4) == 0;
      idx = $urandom % 16;
      if (idx == 2 || idx == 4 || (idx >= 10 && idx <= 13))
        d = (1 << (12 + ($urandom % 14))) - 1;
      else if (idx == 0) d = $urandom % 256;
      else d = $urandom & AMASK;
      pick = $urandom % 6;
      if (pick < 5) begin
        a = m_reg[(pick == 0) ? 1 : (pick == 1) ? 3 : (pick == 2) ? 5 : 6 + ($urandom % 4)];
        a = (a & ~32'h3FFF) + ($urandom % 3 == 0 ? 0 : $urandom % 32'h9000) - ($urandom % 2);
        a = a & AMASK;
      end else a = $urandom & AMASK;
      if (($urandom % 50) == 0) dpr_32k = ~dpr_32k;
      cyc(we, idx, d, a, "R6");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule